// File: doc/BRIEF.md
# Chainable Serial Channel-Command Slave

This block is the serial front end of an eight-channel load-switch controller. A host acting as a mode-0 SPI master (clock idles low, data sampled on the rising clock edge, data changed on the falling edge) sends a one-byte on/off command, most significant bit first. While the command shifts in, the block shifts out a per-channel thermal fault word that it captured when the select line went low. When the select line returns high, the last byte received becomes the channel status that drives the switches.

Frames longer than one byte pass through. The bits that arrived first leave on the serial output after the fault word, so several devices can share one chain and select line. A frame whose bit count is not a whole number of bytes raises a frame error. The frame error and any live thermal fault pull a common active-low fault output. An active-low output enable forces every channel off and clamps the serial output low. After the enable returns, the channels stay off until the host sends a new command.

The serial clock, select, data and enable pins are sampled by a two-flop synchronizer in a system clock running at least four times faster than the serial clock. All edge detection happens in that clock domain.

Top module: `spi_chain_slave`

## Requirements
- R1: After reset, `chanOn` is 0, `frameErr` is 0, `sdoOe` is 0, and `faultN` is 1 while `faultIn` is 0.
- R2: Data on `sdiIn` is sampled on rising `sclkIn` edges while `ssNIn` is low, most significant bit first. After a frame of exactly 8 bits, `chanOn[i]` equals command bit i once `ssNIn` has risen (1 = channel on).
- R3: `chanOn` does not change while `ssNIn` is low. The command takes effect only when the select line rises.
- R4: When `ssNIn` falls, `faultIn` is captured. Its bit 7 appears on `sdoOut` before the first clock edge, and bits 6 down to 0 follow on successive falling edges. Changes on `faultIn` after the select edge do not alter the reply.
- R5: When more than 8 bits are clocked in, `chanOn` takes the last 8. After the 8 fault bits, `sdoOut` repeats the received bits in arrival order, delayed by 8 clocks.
- R6: While `ssNIn` and `outEnNIn` are both high, `sdoOe` is 0 (serial output released).
- R7: If the number of rising clock edges in one select-low window is not a multiple of 8, `frameErr` is set when the select line rises, and `faultN` is driven low.
- R8: A frame whose count is not a multiple of 8 but is at least 8 still commits its last 8 bits. A frame of fewer than 8 bits leaves `chanOn` unchanged.
- R9: `frameErr` clears at the end of the next frame whose bit count is a multiple of 8.
- R10: `faultN` is low whenever any bit of `faultIn` is 1, independently of the serial interface.
- R11: While `outEnNIn` is low, `chanOn` is 0, `sdoOe` is 1 and `sdoOut` is 0. After `outEnNIn` rises, `chanOn` stays 0 until a new command frame ends.
- R12: If a command frame ends in the same system cycle in which the output enable is seen low, the clear wins and `chanOn` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the host, idles low |
| ssNIn | input | 1 | Active-low select |
| sdiIn | input | 1 | Serial command data in |
| outEnNIn | input | 1 | Active-low output enable; low forces all channels off |
| faultIn | input | 8 | Per-channel thermal fault flags, system-clock synchronous |
| chanOn | output | 8 | Committed channel on/off status |
| sdoOut | output | 1 | Serial reply data |
| sdoOe | output | 1 | Drive enable for the serial reply pin |
| frameErr | output | 1 | Last frame had a bit count not a multiple of 8 |
| faultN | output | 1 | Common active-low fault indication |

## Verification
Two functions can act in the same system cycle: committing a command when the select line rises, and clearing the status because the output enable is low. The bench provokes this by raising the select line and lowering the enable at the same instant. Both pins pass through the same synchronizer depth, so the block sees the two events in one cycle. The check passes when `chanOn` is still zero after the enable is released, and when it then takes a following command normally.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  typedef struct packed {
    logic capture;  // select fell: load fault snapshot
    logic shift;    // serial clock rose while selected
    logic update;   // serial clock fell while selected
    logic commit;   // select rose after at least one full word
    logic clear;    // output enable seen low
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_chain_ctrl.sv
module spi_chain_ctrl
  import spi_chain_pkg::*;
#(
  parameter int WORD = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkIn,
  input  logic         ssNIn,
  input  logic         sdiIn,
  input  logic         outEnNIn,
  output ctrlStrobes_t st,
  output logic         sdiBit,
  output logic         ssActive,
  output logic         frameErr
);

  localparam int CNTW = (WORD > 1) ? $clog2(WORD) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(WORD - 1);

  logic [SYNC:0]   sclkPipe, ssPipe, sdiPipe, enPipe;
  logic [CNTW-1:0] bitCnt;
  logic            gotWord;
  logic            ssFall, ssRise, sclkRise, sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      ssPipe   <= '1;
      sdiPipe  <= '0;
      enPipe   <= '1;
    end else begin
      sclkPipe <= {sclkPipe[SYNC-1:0], sclkIn};
      ssPipe   <= {ssPipe[SYNC-1:0], ssNIn};
      sdiPipe  <= {sdiPipe[SYNC-1:0], sdiIn};
      enPipe   <= {enPipe[SYNC-1:0], outEnNIn};
    end
  end

  assign ssActive = !ssPipe[SYNC-1];
  assign ssFall   = ssPipe[SYNC] && !ssPipe[SYNC-1];
  assign ssRise   = !ssPipe[SYNC] && ssPipe[SYNC-1];
  assign sclkRise = ssActive && !sclkPipe[SYNC] && sclkPipe[SYNC-1];
  assign sclkFall = ssActive && sclkPipe[SYNC] && !sclkPipe[SYNC-1];
  assign sdiBit   = sdiPipe[SYNC-1];

  always_comb begin
    st.capture = ssFall;
    st.shift   = sclkRise && !ssFall;
    st.update  = sclkFall && !ssFall;
    st.commit  = ssRise && gotWord;
    st.clear   = !enPipe[SYNC-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      gotWord  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (ssFall) begin
        bitCnt  <= '0;
        gotWord <= 1'b0;
      end else if (sclkRise) begin
        if (bitCnt == LAST) begin
          bitCnt  <= '0;
          gotWord <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (ssRise) frameErr <= (bitCnt != '0);
    end
  end

  // R7
  err_only_at_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ssRise |=> $stable(frameErr));

endmodule

// File: rtl/spi_chain_dpath.sv
module spi_chain_dpath
  import spi_chain_pkg::*;
#(
  parameter int WORD = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    st,
  input  logic            sdiBit,
  input  logic            ssActive,
  input  logic [WORD-1:0] faultIn,
  output logic [WORD-1:0] chanOn,
  output logic            sdoOut,
  output logic            sdoOe
);

  logic [WORD-1:0] shiftReg;
  logic            outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      outBit   <= 1'b0;
    end else begin
      if (st.capture) begin
        shiftReg <= faultIn;
        outBit   <= faultIn[WORD-1];
      end else begin
        if (st.shift)  shiftReg <= {shiftReg[WORD-2:0], sdiBit};
        if (st.update) outBit   <= shiftReg[WORD-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          chanOn <= '0;
    else if (st.clear)  chanOn <= '0;
    else if (st.commit) chanOn <= shiftReg;
  end

  assign sdoOe  = ssActive || st.clear;
  assign sdoOut = st.clear ? 1'b0 : outBit;

  // R11
  clear_empties_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> (chanOn == '0));

  // R3
  status_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.commit && !st.clear) |=> $stable(chanOn));

  // R4
  first_reply_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |=> (outBit == $past(faultIn[WORD-1])));

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int WORD = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclkIn,
  input  logic            ssNIn,
  input  logic            sdiIn,
  input  logic            outEnNIn,
  input  logic [WORD-1:0] faultIn,
  output logic [WORD-1:0] chanOn,
  output logic            sdoOut,
  output logic            sdoOe,
  output logic            frameErr,
  output logic            faultN
);

  ctrlStrobes_t st;
  logic         sdiBit;
  logic         ssActive;

  spi_chain_ctrl #(.WORD(WORD), .SYNC(SYNC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkIn   (sclkIn),
    .ssNIn    (ssNIn),
    .sdiIn    (sdiIn),
    .outEnNIn (outEnNIn),
    .st       (st),
    .sdiBit   (sdiBit),
    .ssActive (ssActive),
    .frameErr (frameErr)
  );

  spi_chain_dpath #(.WORD(WORD)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .sdiBit   (sdiBit),
    .ssActive (ssActive),
    .faultIn  (faultIn),
    .chanOn   (chanOn),
    .sdoOut   (sdoOut),
    .sdoOe    (sdoOe)
  );

  assign faultN = !(frameErr || (|faultIn));

endmodule

// File: tb/spi_chain_slave_tb.sv
module spi_chain_slave_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclkIn = 1'b0, ssNIn = 1'b1, sdiIn = 1'b0, outEnNIn = 1'b1;
  logic [7:0] faultIn = '0;
  logic [7:0] chanOn;
  logic       sdoOut, sdoOe, frameErr, faultN;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  spi_chain_slave u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .ssNIn(ssNIn), .sdiIn(sdiIn),
    .outEnNIn(outEnNIn), .faultIn(faultIn), .chanOn(chanOn), .sdoOut(sdoOut),
    .sdoOe(sdoOe), .frameErr(frameErr), .faultN(faultN)
  );

  typedef struct packed {
    logic [7:0]  n;
    logic [23:0] data;
    logic [7:0]  fault;
    logic [7:0]  late;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'd8,  24'h0000A5, 8'h3C, 8'h3C},
    '{8'd16, 24'h001234, 8'h81, 8'h81},
    '{8'd11, 24'h0005C3, 8'h00, 8'hFF},
    '{8'd5,  24'h000015, 8'h0F, 8'h0F},
    '{8'd8,  24'h000000, 8'hF0, 8'hF0},
    '{8'd24, 24'hABCDEF, 8'h55, 8'h55},
    '{8'd8,  24'h0000FF, 8'h00, 8'h00}
  };

  task automatic waitClk(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one frame; ends with the select rising (and, if dropEn, the enable falling at once).
  task automatic runFrame(input int n, input logic [23:0] data, input logic [7:0] fault,
                          input logic [7:0] late, input logic [7:0] prevStatus,
                          input bit dropEn, output logic [31:0] reply);
    reply = '0;
    faultIn = fault;
    waitClk(2);
    ssNIn = 1'b0;
    waitClk(8);
    faultIn = late;
    for (int i = 0; i < n; i++) begin
      sdiIn = data[n-1-i];
      waitClk(4);
      reply = {reply[30:0], sdoOut};
      sclkIn = 1'b1;
      waitClk(8);
      sclkIn = 1'b0;
      waitClk(4);
    end
    waitClk(4);
    check("R3 status frozen while selected", {24'd0, chanOn}, {24'd0, prevStatus});
    ssNIn = 1'b1;
    if (dropEn) outEnNIn = 1'b0;
    waitClk(8);
  endtask

  logic [7:0]  expStatus;
  logic [31:0] reply, expReply;

  initial begin
    expStatus = 8'h00;
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    // R1 reset state
    check("R1 chanOn", {24'd0, chanOn}, 32'd0);
    check("R1 frameErr/sdoOe/faultN", {29'd0, frameErr, sdoOe, faultN}, 32'b001);

    // Table of frames
    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic expErr;
      n = int'(VECS[v].n);
      runFrame(n, VECS[v].data, VECS[v].fault, VECS[v].late, expStatus, 1'b0, reply);
      if (n >= 8) expStatus = VECS[v].data[7:0];
      expErr = (n % 8) != 0;
      expReply = '0;
      for (int j = 0; j < n; j++) begin
        logic b;
        b = (j < 8) ? VECS[v].fault[7-j] : VECS[v].data[n-1-(j-8)];
        expReply = {expReply[30:0], b};
      end
      // R2 R5 R8 committed status
      check($sformatf("R2/R5/R8 status vec%0d", v), {24'd0, chanOn}, {24'd0, expStatus});
      // R4 R5 reply stream (fault snapshot, then pass-through)
      check($sformatf("R4/R5 reply vec%0d", v), reply, expReply);
      // R7 R9 frame error
      check($sformatf("R7/R9 frameErr vec%0d", v), {31'd0, frameErr}, {31'd0, expErr});
      check($sformatf("R7 faultN vec%0d", v), {31'd0, faultN},
            {31'd0, !(expErr || (|VECS[v].late))});
      // R6 released output
      check($sformatf("R6 sdoOe vec%0d", v), {31'd0, sdoOe}, 32'd0);
    end

    // R10 live fault with no frame error
    faultIn = 8'h10;
    waitClk(2);
    check("R10 faultN with thermal fault", {31'd0, faultN}, 32'd0);
    faultIn = 8'h00;
    waitClk(2);
    check("R10 faultN idle", {31'd0, faultN}, 32'd1);

    // R11 output enable clear
    outEnNIn = 1'b0;
    waitClk(6);
    check("R11 chanOn cleared", {24'd0, chanOn}, 32'd0);
    check("R11 sdo clamped", {30'd0, sdoOe, sdoOut}, 32'b10);
    outEnNIn = 1'b1;
    waitClk(10);
    check("R11 stays off after enable", {24'd0, chanOn}, 32'd0);
    expStatus = 8'h00;
    runFrame(8, 24'h00005A, 8'h00, 8'h00, expStatus, 1'b0, reply);
    check("R11 new command after enable", {24'd0, chanOn}, 32'h5A);
    expStatus = 8'h5A;

    // R12 commit and clear in the same cycle
    runFrame(8, 24'h0000C3, 8'h00, 8'h00, expStatus, 1'b1, reply);
    check("R12 clear wins during enable low", {24'd0, chanOn}, 32'd0);
    outEnNIn = 1'b1;
    waitClk(10);
    check("R12 clear wins after release", {24'd0, chanOn}, 32'd0);
    runFrame(8, 24'h000099, 8'h00, 8'h00, 8'h00, 1'b0, reply);
    check("R12 later command accepted", {24'd0, chanOn}, 32'h99);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule